// File: doc/BRIEF.md
# SDRAM Power-Down Manager

This block sits between the command scheduler of an SDRAM controller and the memory pins. When the host asks for idle and no access is in flight, it drops the clock enable while the command lines carry a no-operation. It classifies the resulting state from the per-bank open-row flags: precharge power-down when every bank is closed, active power-down when any row is open. It reports that class on a mode output for the whole time the clock enable is low.

Because the memory cannot refresh itself while powered down, a residency countdown bounds the time spent with the clock enable low. A refresh-due tick also forces an immediate wake. After the clock enable rises, a configurable run of no-operation cycles follows. Host commands are stalled during that run. A one-cycle ready pulse then hands the pins back to the scheduler. After a forced wake, the block does not power down again until the host drops its idle request or issues a command, so the pending refresh can be serviced.

Top module: `sdram_pd_mgr`

## Requirements
- R1: After a synchronous active-low reset, `cke_o` is 1, `pd_mode_o` is 2'b00, `ready_o` is 0, `host_stall_o` is 0, and with no host command `cmd_o` is the no-operation code 4'b0111 (bit order {cs_n, ras_n, cas_n, we_n}).
- R2: Power-down is entered when `idle_req_i` is 1, `access_busy_i` is 0, `host_cmd_valid_i` is 0 and `refresh_due_i` is 0 at a clock edge. `cke_o` is 0 from the next cycle. While `access_busy_i` is 1, `cke_o` stays 1.
- R3: The mode becomes 2'b01 (precharge power-down) if all `bank_open_i` bits are 0 at entry. It becomes 2'b10 (active power-down) if any bit is 1. It holds that value while `cke_o` is 0, even if the bank flags change.
- R4: While `cke_o` is 0, `cmd_o` is 4'b0111 whatever the host presents, and `host_stall_o` is 1.
- R5: When `idle_req_i` falls during power-down, `cke_o` returns to 1 in the next cycle and `pd_mode_o` returns to 2'b00.
- R6: `cke_o` is never 0 for more than RES_LIMIT consecutive cycles. Exit is forced even while `idle_req_i` stays 1.
- R7: A `refresh_due_i` tick during power-down makes `cke_o` 1 in the next cycle. A tick in normal mode blocks entry in that cycle.
- R8: After `cke_o` rises, exactly EXIT_NOPS cycles follow with `cmd_o` at 4'b0111, `host_stall_o` at 1 and mode 2'b00. `ready_o` is then 1 for exactly one cycle, the first cycle with `host_stall_o` at 0.
- R9: After a forced exit (R6 or R7), the block does not re-enter power-down until `idle_req_i` has been 0 or a host command has been issued at some clock edge.
- R10: In normal mode with `host_stall_o` at 0, `cmd_o` equals `host_cmd_i` in the same cycle when `host_cmd_valid_i` is 1, and is 4'b0111 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_req_i | input | 1 | Host requests power-down |
| bank_open_i | input | NBANK | Per-bank open-row flags |
| access_busy_i | input | 1 | A read or write burst is in progress |
| refresh_due_i | input | 1 | Refresh-due tick |
| host_cmd_valid_i | input | 1 | Scheduler presents a command |
| host_cmd_i | input | 4 | Scheduler command {cs_n, ras_n, cas_n, we_n} |
| host_stall_o | output | 1 | Scheduler must hold its command |
| cke_o | output | 1 | Clock enable to the memory |
| cmd_o | output | 4 | Command to the memory {cs_n, ras_n, cas_n, we_n} |
| pd_mode_o | output | 2 | 00 normal, 01 precharge power-down, 10 active power-down |
| ready_o | output | 1 | One-cycle pulse when the pins return to the scheduler |

## Verification
The bench goes after bank flags that change during residency: a design that sampled them live would flip between the two power-down classes mid-residency. It holds the idle request high through a timeout and checks the exact low-clock-enable count. An off-by-one counter would overstay the refresh budget, and a design without the re-arm guard would fall straight back into power-down and starve the refresh. It counts the wake-up no-operation cycles against the ready pulse, because an early pulse would let a command reach a device still inside its exit time. It also checks that host commands presented while powered down never reach the pins and that a busy flag prevents entry.

// File: rtl/sdram_pd_pkg.sv
// Package: shared encodings for the SDRAM power-down manager.
// Assumes command bits are ordered {cs_n, ras_n, cas_n, we_n}.
package sdram_pd_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_PRE_PD = 2'b01,
        MODE_ACT_PD = 2'b10
    } pd_mode_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_PD   = 2'b01,
        ST_WAKE = 2'b10
    } pd_state_e;

    localparam logic [3:0] CMD_NOP = 4'b0111;

endpackage

// File: rtl/pd_bank_classify.sv
// Module: reduces per-bank open-row flags to the power-down class that
// an entry at this cycle would produce. Purely combinational.
// Assumes flags are valid in every cycle in which entry may occur.
module pd_bank_classify
    import sdram_pd_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic [NBANK-1:0] bank_open_i,
    output pd_mode_e         entry_mode_o
);

    logic [NBANK:0] open_chain;

    assign open_chain[0] = 1'b0;

    // OR chain across banks, one stage per bank.
    genvar gi;
    generate
        for (gi = 0; gi < NBANK; gi++) begin : g_bank
            assign open_chain[gi+1] = open_chain[gi] | bank_open_i[gi];
        end
    endgenerate

    // Any open row means active power-down, otherwise precharge power-down.
    always_comb begin
        entry_mode_o = open_chain[NBANK] ? MODE_ACT_PD : MODE_PRE_PD;
    end

endmodule

// File: rtl/pd_countdown.sv
// Module: loadable down-counter that saturates at zero.
// Used for both the residency bound and the wake-up NOP run.
// Assumes load and enable are never asserted together.
module pd_countdown #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         en_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Load, decrement or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (en_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    a_r6_no_load_and_dec: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && en_i));

endmodule

// File: rtl/pd_ctrl_fsm.sv
// Module: power-down sequencer. It owns the clock enable, the command mux,
// the mode register, the ready pulse and the re-arm guard after a forced wake.
// Assumes the counters signal zero one cycle after they are loaded with zero.
module pd_ctrl_fsm
    import sdram_pd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_req_i,
    input  logic       access_busy_i,
    input  logic       refresh_due_i,
    input  logic       host_cmd_valid_i,
    input  logic [3:0] host_cmd_i,
    input  pd_mode_e   entry_mode_i,
    input  logic       res_zero_i,
    input  logic       wake_zero_i,
    output logic       res_load_o,
    output logic       res_en_o,
    output logic       wake_load_o,
    output logic       wake_en_o,
    output logic       cke_o,
    output logic [3:0] cmd_o,
    output logic [1:0] pd_mode_o,
    output logic       ready_o,
    output logic       host_stall_o
);

    pd_state_e state_q;
    pd_mode_e  mode_q;
    logic      cke_q;
    logic      ready_q;
    logic      hold_q;
    logic      enter_ok;
    logic      pd_exit;
    logic      forced_exit;
    logic      wake_done;

    // Entry, exit and wake completion conditions.
    always_comb begin
        enter_ok    = (state_q == ST_RUN) && idle_req_i && !access_busy_i &&
                      !host_cmd_valid_i && !refresh_due_i && !hold_q;
        pd_exit     = (state_q == ST_PD) &&
                      (!idle_req_i || refresh_due_i || res_zero_i);
        forced_exit = pd_exit && idle_req_i;
        wake_done   = (state_q == ST_WAKE) && wake_zero_i;
    end

    // Counter controls.
    assign res_load_o  = enter_ok;
    assign res_en_o    = (state_q == ST_PD) && !pd_exit;
    assign wake_load_o = pd_exit;
    assign wake_en_o   = (state_q == ST_WAKE) && !wake_done;

    // State, clock enable, mode and ready registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cke_q   <= 1'b1;
            mode_q  <= MODE_NORMAL;
            ready_q <= 1'b0;
        end else begin
            ready_q <= wake_done;
            case (state_q)
                ST_RUN: begin
                    if (enter_ok) begin
                        state_q <= ST_PD;
                        cke_q   <= 1'b0;
                        mode_q  <= entry_mode_i;
                    end
                end
                ST_PD: begin
                    if (pd_exit) begin
                        state_q <= ST_WAKE;
                        cke_q   <= 1'b1;
                        mode_q  <= MODE_NORMAL;
                    end
                end
                ST_WAKE: begin
                    if (wake_done) begin
                        state_q <= ST_RUN;
                    end
                end
                default: begin
                    state_q <= ST_RUN;
                    cke_q   <= 1'b1;
                    mode_q  <= MODE_NORMAL;
                end
            endcase
        end
    end

    // Re-arm guard: set by a forced wake, cleared by idle drop or a host command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (forced_exit) begin
            hold_q <= 1'b1;
        end else if (!idle_req_i || host_cmd_valid_i) begin
            hold_q <= 1'b0;
        end
    end

    // Command mux: pass-through only in normal mode.
    always_comb begin
        if ((state_q == ST_RUN) && host_cmd_valid_i) begin
            cmd_o = host_cmd_i;
        end else begin
            cmd_o = CMD_NOP;
        end
    end

    assign cke_o        = cke_q;
    assign pd_mode_o    = mode_q;
    assign ready_o      = ready_q;
    assign host_stall_o = (state_q != ST_RUN);

    a_r4_nop_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o |-> (cmd_o == CMD_NOP) && host_stall_o);

    a_r3_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_o && $past(!cke_o)) |-> $stable(pd_mode_o));

    a_r2_entry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_o) |-> $past(idle_req_i && !access_busy_i && !refresh_due_i));

    a_r7_refresh_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_o && refresh_due_i) |=> cke_o);

    a_r8_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);

    a_r8_wake_normal_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_o && host_stall_o) |-> (pd_mode_o == MODE_NORMAL));

endmodule

// File: rtl/sdram_pd_mgr.sv
// Module: top of the SDRAM power-down manager. Connects bank classification,
// residency countdown, wake countdown and the sequencer.
// Assumes RES_LIMIT is chosen below the refresh interval and EXIT_NOPS >= 1.
module sdram_pd_mgr
    import sdram_pd_pkg::*;
#(
    parameter int NBANK     = 4,
    parameter int RES_LIMIT = 64,
    parameter int EXIT_NOPS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_req_i,
    input  logic [NBANK-1:0] bank_open_i,
    input  logic             access_busy_i,
    input  logic             refresh_due_i,
    input  logic             host_cmd_valid_i,
    input  logic [3:0]       host_cmd_i,
    output logic             host_stall_o,
    output logic             cke_o,
    output logic [3:0]       cmd_o,
    output logic [1:0]       pd_mode_o,
    output logic             ready_o
);

    localparam int RES_W  = (RES_LIMIT > 1) ? $clog2(RES_LIMIT) : 1;
    localparam int WAKE_W = (EXIT_NOPS > 1) ? $clog2(EXIT_NOPS) : 1;
    localparam int CHK_W  = $clog2(RES_LIMIT + 2);
    localparam logic [RES_W-1:0]  RES_LOAD  = RES_W'(RES_LIMIT - 1);
    localparam logic [WAKE_W-1:0] WAKE_LOAD = WAKE_W'(EXIT_NOPS - 1);

    pd_mode_e entry_mode;
    logic     res_load, res_en, res_zero;
    logic     wake_load, wake_en, wake_zero;

    pd_bank_classify #(.NBANK(NBANK)) u_classify (
        .bank_open_i  (bank_open_i),
        .entry_mode_o (entry_mode)
    );

    pd_countdown #(.W(RES_W)) u_res_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (res_load),
        .load_val_i (RES_LOAD),
        .en_i       (res_en),
        .zero_o     (res_zero)
    );

    pd_countdown #(.W(WAKE_W)) u_wake_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wake_load),
        .load_val_i (WAKE_LOAD),
        .en_i       (wake_en),
        .zero_o     (wake_zero)
    );

    pd_ctrl_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .idle_req_i       (idle_req_i),
        .access_busy_i    (access_busy_i),
        .refresh_due_i    (refresh_due_i),
        .host_cmd_valid_i (host_cmd_valid_i),
        .host_cmd_i       (host_cmd_i),
        .entry_mode_i     (entry_mode),
        .res_zero_i       (res_zero),
        .wake_zero_i      (wake_zero),
        .res_load_o       (res_load),
        .res_en_o         (res_en),
        .wake_load_o      (wake_load),
        .wake_en_o        (wake_en),
        .cke_o            (cke_o),
        .cmd_o            (cmd_o),
        .pd_mode_o        (pd_mode_o),
        .ready_o          (ready_o),
        .host_stall_o     (host_stall_o)
    );

    // Independent residency monitor: counts consecutive low-CKE cycles.
    logic [CHK_W-1:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || cke_o) begin
            low_run_q <= '0;
        end else if (low_run_q <= CHK_W'(RES_LIMIT)) begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    a_r6_residency_bound: assert property (@(posedge clk) disable iff (!rst_n)
        low_run_q <= CHK_W'(RES_LIMIT));

endmodule

// File: tb/sdram_pd_mgr_tb.sv
module sdram_pd_mgr_tb;

    localparam int NB = 4;
    localparam int RL = 8;
    localparam int EN = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          idle_req = 1'b0;
    logic [NB-1:0] bank_open = '0;
    logic          busy = 1'b0;
    logic          refresh = 1'b0;
    logic          hvalid = 1'b0;
    logic [3:0]    hcmd = 4'b0111;
    logic          stall, cke, ready;
    logic [3:0]    cmd;
    logic [1:0]    mode;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sdram_pd_mgr #(.NBANK(NB), .RES_LIMIT(RL), .EXIT_NOPS(EN)) u_dut (
        .clk(clk), .rst_n(rst_n), .idle_req_i(idle_req), .bank_open_i(bank_open),
        .access_busy_i(busy), .refresh_due_i(refresh), .host_cmd_valid_i(hvalid),
        .host_cmd_i(hcmd), .host_stall_o(stall), .cke_o(cke), .cmd_o(cmd),
        .pd_mode_o(mode), .ready_o(ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called at the negedge where cke is first seen high after power-down.
    task automatic wait_ready(input string req);
        int n = 0;
        while (stall && n < 20) begin
            chk(cmd == 4'b0111, req, "wake cmd", cmd, 7);
            n++;
            @(negedge clk);
        end
        chk(n == EN, req, "wake NOP cycles", n, EN);
        chk(ready == 1'b1, req, "ready pulse", ready, 1);
        @(negedge clk);
        chk(ready == 1'b0, req, "ready width", ready, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cke == 1'b1, "R1", "cke", cke, 1);
        chk(mode == 2'b00, "R1", "mode", mode, 0);
        chk(ready == 1'b0 && stall == 1'b0, "R1", "ready|stall", ready | stall, 0);
        chk(cmd == 4'b0111, "R10", "idle cmd NOP", cmd, 7);
    endtask

    task automatic t_precharge_pd();
        bank_open = '0;
        idle_req  = 1'b1;
        @(negedge clk);
        chk(cke == 1'b0, "R2", "entry cke", cke, 0);
        chk(mode == 2'b01, "R3", "precharge mode", mode, 1);
        chk(stall == 1'b1, "R4", "stall", stall, 1);
        hvalid = 1'b1;
        hcmd   = 4'b0001;
        #1;
        chk(cmd == 4'b0111, "R4", "host cmd blocked", cmd, 7);
        bank_open = 4'hF;
        @(negedge clk);
        chk(mode == 2'b01, "R3", "mode stable", mode, 1);
        hvalid   = 1'b0;
        idle_req = 1'b0;
        @(negedge clk);
        chk(cke == 1'b1, "R5", "exit cke", cke, 1);
        chk(mode == 2'b00, "R5", "exit mode", mode, 0);
        wait_ready("R8");
        bank_open = '0;
    endtask

    task automatic t_active_pd();
        bank_open = 4'b0100;
        idle_req  = 1'b1;
        @(negedge clk);
        chk(mode == 2'b10, "R3", "active mode", mode, 2);
        idle_req = 1'b0;
        @(negedge clk);
        chk(cke == 1'b1, "R5", "exit cke", cke, 1);
        wait_ready("R8");
        bank_open = '0;
    endtask

    task automatic t_busy_blocks();
        busy     = 1'b1;
        idle_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(cke == 1'b1, "R2", "busy blocks entry", cke, 1);
        end
        busy = 1'b0;
        @(negedge clk);
        chk(cke == 1'b0, "R2", "entry after busy", cke, 0);
        idle_req = 1'b0;
        @(negedge clk);
        wait_ready("R8");
    endtask

    task automatic t_residency();
        int n = 0;
        idle_req = 1'b1;
        @(negedge clk);
        while (!cke && n < 30) begin
            n++;
            @(negedge clk);
        end
        chk(n == RL, "R6", "low cycles", n, RL);
        wait_ready("R8");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(cke == 1'b1, "R9", "no re-entry", cke, 1);
        end
        idle_req = 1'b0;
        @(negedge clk);
        idle_req = 1'b1;
        @(negedge clk);
        chk(cke == 1'b0, "R9", "re-armed by idle drop", cke, 0);
        idle_req = 1'b0;
        @(negedge clk);
        wait_ready("R8");
    endtask

    task automatic t_refresh();
        idle_req = 1'b1;
        @(negedge clk);
        chk(cke == 1'b0, "R2", "entry", cke, 0);
        @(negedge clk);
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
        chk(cke == 1'b1, "R7", "refresh wakes", cke, 1);
        wait_ready("R8");
        hvalid = 1'b1;
        hcmd   = 4'b0011;
        #1;
        chk(cmd == 4'b0011, "R10", "pass-through", cmd, 3);
        chk(stall == 1'b0, "R10", "no stall", stall, 0);
        @(negedge clk);
        chk(cke == 1'b1, "R9", "held after refresh", cke, 1);
        hvalid  = 1'b0;
        refresh = 1'b1;
        @(negedge clk);
        chk(cke == 1'b1, "R7", "tick blocks entry", cke, 1);
        refresh = 1'b0;
        @(negedge clk);
        chk(cke == 1'b0, "R9", "re-armed by command", cke, 0);
        idle_req = 1'b0;
        @(negedge clk);
        wait_ready("R8");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_precharge_pd();
        t_active_pd();
        t_busy_blocks();
        t_residency();
        t_refresh();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule